// File: doc/BRIEF.md
# Pre-Add Multiply-Accumulate Pipeline

This block is a signed fixed-point datapath. Each cycle it takes two addend operands, adds them, multiplies the sum by a coefficient operand and folds the product into a wide accumulator. A seed control starts a new running sum: instead of adding the product to the previous total, the accumulator takes the product plus an externally supplied seed value. All values are two's complement, and the accumulator wraps modulo 2^ACC_W.

The operand widths and the pipeline depth are parameters. `LATENCY` chooses from 0 to 4 cycles, and each setting places a fixed set of input, post-multiplier and output registers. For a depth of 2 there are two placements, chosen by `L2_OUT_REG`. The enable and seed controls, and the seed value, travel through the same stages as the operands. Each control therefore acts on the product it was issued with. A synchronous active-low reset empties every stage and the accumulator on one clock edge.

Top module: `preadd_mac`

## Requirements
- R1: The product is (add_x + add_y) * mul_k. Every input is signed two's complement, the sum is formed one bit wider than add_x/add_y, and the product is sign-extended to ACC_W bits.
- R2: An operation issued with en=1 and ld_en=0 sets the accumulator to its previous value plus the product, modulo 2^ACC_W.
- R3: An operation issued with en=1 and ld_en=1 sets the accumulator to the product plus ld_value, modulo 2^ACC_W. The previous total is discarded.
- R4: An operation issued with en=0 leaves the stored accumulator unchanged, whatever its operands, ld_en and ld_value are.
- R5: For LATENCY of 1 to 4, the effect of an operation appears on acc_out after exactly LATENCY rising clock edges. For LATENCY 0, acc_out is combinational and equals (ld_en ? ld_value : stored total) + product in the same cycle, and the stored total is updated on the next edge when en=1.
- R6: Register placement follows LATENCY. 1: a single register after the multiplier, which also holds the total. 2 with L2_OUT_REG=0: input registers plus that register. 2 with L2_OUT_REG=1: a post-multiplier register plus an output register. 3: one input stage plus the post-multiplier and output registers. 4: two input stages plus the post-multiplier and output registers. Both LATENCY 2 placements have the same cycle behaviour.
- R7: en, ld_en and ld_value are delayed alongside the operands, so each control applies only to the operation it was presented with.
- R8: While rst_n=0 at a rising edge, every pipeline stage and the accumulator are cleared to zero. Operations in flight are discarded, and for LATENCY of 1 or more acc_out reads zero until new operations arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Operation enable, travels with the operands |
| add_x | input | PRE_W | First signed addend |
| add_y | input | PRE_W | Second signed addend |
| mul_k | input | MUL_W | Signed coefficient |
| ld_en | input | 1 | Seed the accumulator with product plus ld_value |
| ld_value | input | ACC_W | Seed value |
| acc_out | output | ACC_W | Accumulated total |

## Verification
The hardest situation to reach from the ports is a reset arriving while enabled operations are still inside a deep pipeline. If the pipeline is not flushed, those operations would resurface after reset is released. The bench keeps issuing enabled, seeding operations right up to the reset edge. It then checks every latency variant: outputs must read zero until operations issued after the reset arrive. A second difficulty is telling a misaligned control from a wrong sum. For that, seed and enable patterns are interleaved at co-prime periods against all operand combinations of a small configuration, and six instances covering every latency placement are compared against one arithmetic model.

// File: rtl/preadd_mac_pkg.sv
// Package: preadd_mac_pkg
// Shared configuration helpers for the pre-add multiply-accumulate block.
// Maps a latency setting to the number of input register stages and to
// the presence of the post-multiplier register. Assumes LATENCY is 0..4.
package preadd_mac_pkg;

    // Larger of two integers, used to size the internal product.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Number of register stages placed ahead of the pre-adder.
    function automatic int in_stages(input int lat, input bit l2_out);
        if (lat == 4) return 2;
        if (lat == 3) return 1;
        if (lat == 2 && !l2_out) return 1;
        return 0;
    endfunction

    // Whether a register separates the multiplier from the accumulator.
    function automatic int mid_stages(input int lat, input bit l2_out);
        if (lat >= 3) return 1;
        if (lat == 2 && l2_out) return 1;
        return 0;
    endfunction

endpackage

// File: rtl/pam_delay.sv
// Module: pam_delay
// Fixed-depth shift register for a packed bundle of data and controls.
// DEPTH of zero turns it into a wire. Every stage advances each clock
// and is cleared by the synchronous active-low reset. Assumes DEPTH is small.
module pam_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    generate
        if (DEPTH == 0) begin : g_wire
            // Pass-through when no stage is configured.
            assign d_out = d_in;
        end else begin : g_regs
            logic [W-1:0] pipe_q [DEPTH];

            // Shift the bundle one stage per clock; reset clears all stages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
                end else begin
                    pipe_q[0] <= d_in;
                    for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
                end
            end

            assign d_out = pipe_q[DEPTH-1];

            AST_STAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> d_out == '0); // R8
        end
    endgenerate

endmodule

// File: rtl/pam_preadd_mult.sv
// Module: pam_preadd_mult
// Combinational signed pre-adder followed by a multiplier.
// The sum is one bit wider than the addends. The product is formed at
// the larger of ACC_W and its natural width, then trimmed to ACC_W.
// Assumes ACC_W does not exceed the natural product width by design intent
// only where wrap-around is acceptable.
module pam_preadd_mult #(
    parameter int PRE_W = 24,
    parameter int MUL_W = 18,
    parameter int ACC_W = 48
) (
    input  logic [PRE_W-1:0] op_x,
    input  logic [PRE_W-1:0] op_y,
    input  logic [MUL_W-1:0] op_k,
    output logic [ACC_W-1:0] prod
);

    localparam int SUM_W  = PRE_W + 1;
    localparam int NAT_W  = SUM_W + MUL_W;
    localparam int EXT_W  = preadd_mac_pkg::max_int(ACC_W, NAT_W);

    logic [SUM_W-1:0] sum;
    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] k_ext;
    logic [EXT_W-1:0] full;

    // Sign-extended pre-add, one guard bit so the sum cannot overflow.
    always_comb sum = {op_x[PRE_W-1], op_x} + {op_y[PRE_W-1], op_y};

    // Extend both factors to the product width and multiply modulo 2^EXT_W.
    always_comb begin
        sum_ext = {{(EXT_W-SUM_W){sum[SUM_W-1]}}, sum};
        k_ext   = {{(EXT_W-MUL_W){op_k[MUL_W-1]}}, op_k};
        full    = sum_ext * k_ext;
    end

    assign prod = full[ACC_W-1:0];

endmodule

// File: rtl/pam_accum.sv
// Module: pam_accum
// Accumulator register with a seed path. The next total is the product
// plus either the stored total or the seed value, and it is stored only
// when the (already aligned) enable is high. With COMB_OUT set, the output
// shows the next total combinationally; otherwise it shows the register.
module pam_accum #(
    parameter int ACC_W    = 48,
    parameter bit COMB_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ld_en,
    input  logic [ACC_W-1:0] ld_value,
    input  logic [ACC_W-1:0] prod,
    output logic [ACC_W-1:0] acc_out
);

    logic [ACC_W-1:0] total_q;
    logic [ACC_W-1:0] total_nxt;

    // Choose the addend base: seed value or running total.
    always_comb total_nxt = (ld_en ? ld_value : total_q) + prod;

    // Hold or update the running total; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)  total_q <= '0;
        else if (en) total_q <= total_nxt;
    end

    generate
        if (COMB_OUT) begin : g_comb
            assign acc_out = total_nxt;
        end else begin : g_reg
            assign acc_out = total_q;
        end
    endgenerate

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(total_q)); // R4
    AST_TOTAL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> total_q == '0); // R8

endmodule

// File: rtl/preadd_mac.sv
// Module: preadd_mac
// Pre-add multiply-accumulate pipeline. Operands and controls pass through
// a latency-dependent number of input stages, the pre-adder/multiplier, an
// optional post-multiplier stage and the accumulator register. Assumes
// LATENCY in 0..4, PRE_W 1..24, MUL_W 1..18, ACC_W 1..48.
module preadd_mac #(
    parameter int PRE_W      = 24,
    parameter int MUL_W      = 18,
    parameter int ACC_W      = 48,
    parameter int LATENCY    = 3,
    parameter bit L2_OUT_REG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] add_x,
    input  logic [PRE_W-1:0] add_y,
    input  logic [MUL_W-1:0] mul_k,
    input  logic             ld_en,
    input  logic [ACC_W-1:0] ld_value,
    output logic [ACC_W-1:0] acc_out
);

    localparam int N_IN  = preadd_mac_pkg::in_stages(LATENCY, L2_OUT_REG);
    localparam int N_MID = preadd_mac_pkg::mid_stages(LATENCY, L2_OUT_REG);
    localparam int IN_W  = 2 + ACC_W + 2*PRE_W + MUL_W;
    localparam int MID_W = 2 + 2*ACC_W;
    localparam bit COMB  = (LATENCY == 0);

    logic [IN_W-1:0]  in_bus, in_bus_d;
    logic [MID_W-1:0] mid_bus, mid_bus_d;

    logic             s1_en, s1_ld;
    logic [ACC_W-1:0] s1_val;
    logic [PRE_W-1:0] s1_x, s1_y;
    logic [MUL_W-1:0] s1_k;
    logic [ACC_W-1:0] s1_prod;

    logic             s2_en, s2_ld;
    logic [ACC_W-1:0] s2_val, s2_prod;

    // Bundle operands with their controls so they stay aligned.
    assign in_bus = {en, ld_en, ld_value, add_x, add_y, mul_k};

    pam_delay #(.W(IN_W), .DEPTH(N_IN)) i_in_stages (
        .clk(clk), .rst_n(rst_n), .d_in(in_bus), .d_out(in_bus_d)
    );

    assign {s1_en, s1_ld, s1_val, s1_x, s1_y, s1_k} = in_bus_d;

    pam_preadd_mult #(.PRE_W(PRE_W), .MUL_W(MUL_W), .ACC_W(ACC_W)) i_mult (
        .op_x(s1_x), .op_y(s1_y), .op_k(s1_k), .prod(s1_prod)
    );

    assign mid_bus = {s1_en, s1_ld, s1_val, s1_prod};

    pam_delay #(.W(MID_W), .DEPTH(N_MID)) i_mid_stage (
        .clk(clk), .rst_n(rst_n), .d_in(mid_bus), .d_out(mid_bus_d)
    );

    assign {s2_en, s2_ld, s2_val, s2_prod} = mid_bus_d;

    pam_accum #(.ACC_W(ACC_W), .COMB_OUT(COMB)) i_accum (
        .clk(clk), .rst_n(rst_n), .en(s2_en), .ld_en(s2_ld),
        .ld_value(s2_val), .prod(s2_prod), .acc_out(acc_out)
    );

    // ---------------- assertions ----------------
    logic [2:0] since_rst;
    logic       sum_zero;
    localparam logic [2:0] LAT3 = 3'(LATENCY);

    // Cycles since reset release, saturating, so $past windows stay valid.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // Addends cancel, so a seeded operation must return the seed alone.
    always_comb sum_zero = (({add_x[PRE_W-1], add_x} + {add_y[PRE_W-1], add_y}) == '0);

    AST_ZERO_COEFF: assert property (@(posedge clk) disable iff (!rst_n)
        s1_k == '0 |-> s1_prod == '0); // R1

    generate
        if (LATENCY == 0) begin : g_chk_comb
            AST_SEED_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
                ld_en && sum_zero |-> acc_out == ld_value); // R3
        end else begin : g_chk_pipe
            AST_SEED_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst >= LAT3) && $past(en && ld_en && sum_zero, LATENCY)
                |-> acc_out == $past(ld_value, LATENCY)); // R7
        end
    endgenerate

endmodule

// File: tb/test_preadd_mac.sv
// Bench: six instances (every latency placement) on shared stimulus,
// compared against one arithmetic model of the running total.
module test_preadd_mac;

    localparam int PW = 3;
    localparam int MW = 3;
    localparam int AW = 10;
    localparam int NI = 6;
    localparam int LATS [NI] = '{0, 1, 2, 2, 3, 4};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [PW-1:0] add_x = '0;
    logic [PW-1:0] add_y = '0;
    logic [MW-1:0] mul_k = '0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_value = '0;
    logic [AW-1:0] dut_out [NI];

    int tests = 0;
    int fails = 0;
    int hist [4096];
    int n_issue = 0;
    int base = 0;
    int total = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    for (genvar k = 0; k < NI; k++) begin : g_dut
        preadd_mac #(
            .PRE_W(PW), .MUL_W(MW), .ACC_W(AW),
            .LATENCY(LATS[k]), .L2_OUT_REG(k == 3)
        ) i_preadd_mac (
            .clk(clk), .rst_n(rst_n), .en(en), .add_x(add_x), .add_y(add_y),
            .mul_k(mul_k), .ld_en(ld_en), .ld_value(ld_value),
            .acc_out(dut_out[k])
        );
    end

    task automatic check(input int k, input int exp, input string tag);
        tests++;
        if (int'(dut_out[k]) != exp) begin
            fails++;
            $display("FAIL %s R5 R6 inst=%0d lat=%0d actual=%0d expected=%0d",
                     tag, k, LATS[k], dut_out[k], exp);
        end
    endtask

    // One issue: check pipelined outputs, drive, check combinational output.
    task automatic step(input int a, input int b, input int c, input bit ld,
                        input int ldv, input bit ce, input string tag);
        int p, nxt;
        for (int k = 1; k < NI; k++) begin
            if (n_issue - LATS[k] >= base) check(k, hist[n_issue - LATS[k]], tag);
            else check(k, 0, (base > 0) ? "R8 flush" : tag);
        end
        add_x = PW'(a); add_y = PW'(b); mul_k = MW'(c);
        ld_en = ld; ld_value = AW'(ldv); en = ce;
        p = ((a + b) * c) & ((1 << AW) - 1);
        nxt = ((ld ? ldv : total) + p) & ((1 << AW) - 1);
        if (ce) total = nxt;
        hist[n_issue] = total;
        n_issue++;
        #1 check(0, nxt, tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int k = 0; k < NI; k++) check(k, 0, "R8 reset state");
        rst_n = 1'b1;
        // R1 R2: every operand combination, plain accumulation.
        for (int a = -4; a < 4; a++)
            for (int b = -4; b < 4; b++)
                for (int c = -4; c < 4; c++)
                    step(a, b, c, 1'b0, 0, 1'b1, "R1 R2");
        // R3 R4 R7: seeds and idle cycles interleaved at co-prime periods.
        for (int i = 0; i < 300; i++)
            step(((i*5+1) % 8) - 4, ((i*3+2) % 8) - 4, ((i*7) % 8) - 4,
                 (i % 6 == 2) || (i % 11 == 0), (i*97 + 900) % 1024,
                 (i % 4 != 1), "R3 R4 R7");
        // R8: enabled seeding operations in flight when reset arrives.
        for (int i = 0; i < 6; i++) step(3, 2, -3, 1'b1, 500 + i, 1'b1, "R3");
        add_x = 3'd3; en = 1'b1; ld_en = 1'b1; ld_value = 10'd77;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        base = n_issue;
        total = 0;
        for (int i = 0; i < 8; i++) step(1, 1, 1, 1'b0, 0, 1'b0, "R4 R8");
        for (int i = 0; i < 40; i++)
            step((i % 8) - 4, 3 - (i % 8), ((i*3) % 8) - 4, (i % 9 == 4),
                 (i*41) % 1024, (i % 3 != 0), "R2 R3");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R5 actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule